// File: doc/BRIEF.md
# Thermal Sensor Scan Scheduler

This block decides when each of up to four temperature sensing points in one thermal controller is sampled. A sampling request is a one-cycle pulse on `req_valid` with the sensor number on `req_sensor`. The block uses an interval value of N units to mean a wait of N × period × 256 input clock cycles. It sends a burst of requests to one sensor, then moves to the next enabled sensor. After the highest enabled sensor it waits out a round gap and starts again from the lowest enabled sensor.

Each sensor has a 3-bit burst code that sets how many samples it takes per round. Each sensor also has an immediate flag. A flagged sensor takes a single sample and hands over to the next sensor one cycle later. Three separate waits are programmable: between samples of the same sensor (filter), between the last sample of one sensor and the first of the next (sensor), and after the last sensor of a round (group). A master enable clears the whole scheduler while it is low.

Top module: `scan_sched`

## Requirements
- R1: While `clk_en` is 0 no request is issued and all sequencing state returns to idle. After `clk_en` goes high again the scan restarts from the lowest enabled sensor, whatever was pending before.
- R2: The first request is issued in the cycle after the first clock edge that samples `clk_en` = 1 with at least one sensor enabled. It targets the lowest-numbered enabled sensor.
- R3: A wait of N units lasts exactly N × `period_unit` × 256 clock cycles, measured from the start of one request to the start of the next. If that product is 0, the wait is 1 cycle, which makes the two requests back to back.
- R4: The 3-bit burst code of sensor i is `filt_code[3i+2:3i]`. Codes 0, 1, 2, 3, 4 and 5 give 1, 2, 4, 6, 10 and 18 samples per round. Codes 6 and 7 give 1 sample.
- R5: Consecutive samples of the same sensor are separated by the filter wait (`filt_ival` units).
- R6: After the last sample of a sensor, if a higher-numbered sensor is enabled, the next request goes to the nearest such sensor after the sensor wait (`sens_ival` units). Disabled sensors between them cost no time.
- R7: After the last sample of the highest enabled sensor, the group wait (`grp_ival` units) passes. The round then restarts at the lowest enabled sensor.
- R8: A sensor whose `imm_en` bit is set takes exactly 1 sample, whatever its burst code. If a higher enabled sensor exists, that sensor's request follows 1 cycle later. Otherwise the group wait still applies.
- R9: With `sensor_en` all zero, no request is ever issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Master enable; 0 holds the scheduler cleared |
| sensor_en | input | 4 | One enable bit per sensing point |
| imm_en | input | 4 | One immediate-mode bit per sensing point |
| filt_code | input | 12 | Burst code per sensor, 3 bits each, sensor 0 lowest |
| period_unit | input | 10 | Unit length in multiples of 256 cycles |
| filt_ival | input | 10 | Wait between samples of one sensor, in units |
| sens_ival | input | 10 | Wait between sensors, in units |
| grp_ival | input | 10 | Wait after the last sensor of a round, in units |
| req_valid | output | 1 | One-cycle sample request |
| req_sensor | output | 2 | Sensor index of the request |

## Verification
The first request is due one cycle after the edge that sees the enable. Every later request is due exactly its wait length after the previous one. The bench drives inputs on the falling edge and samples `req_valid` once per falling edge. It counts the falling edges between requests and compares each count with the product worked out from the requirements: 1 cycle for a zero product, 256 or 512 cycles for one or two units. The "nothing happens" cases (disabled, empty map) are watched for several hundred to two thousand cycles. That is longer than any wait they could have started.

// File: rtl/scan_sched_pkg.sv
package scan_sched_pkg;

    localparam int FCODE_W = 3;
    localparam int SMP_W   = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } scan_st_e;

    // Samples per round for a burst code; unused codes mean one sample.
    function automatic logic [SMP_W-1:0] burst_len(input logic [FCODE_W-1:0] code);
        logic [SMP_W-1:0] n;
        case (code)
            3'd1:    n = 5'd2;
            3'd2:    n = 5'd4;
            3'd3:    n = 5'd6;
            3'd4:    n = 5'd10;
            3'd5:    n = 5'd18;
            default: n = 5'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/scan_delay.sv
// Converts an interval in units to a cycle count; a zero product becomes one cycle.
module scan_delay #(
    parameter int IVAL_W     = 10,
    parameter int UNIT_SHIFT = 8,
    localparam int CNT_W     = 2 * IVAL_W + UNIT_SHIFT
) (
    input  logic [IVAL_W-1:0] units,
    input  logic [IVAL_W-1:0] period,
    output logic [CNT_W-1:0]  cycles
);
    logic [CNT_W-1:0] prod;

    always_comb begin
        prod   = (CNT_W'(units) * CNT_W'(period)) << UNIT_SHIFT;
        cycles = (prod == '0) ? CNT_W'(1) : prod;
    end
endmodule

// File: rtl/scan_pick.sv
// Finds the lowest enabled sensor and the nearest enabled sensor above the current one.
module scan_pick #(
    parameter int N_SENS = 4,
    localparam int IDX_W = $clog2(N_SENS)
) (
    input  logic [N_SENS-1:0] en,
    input  logic [IDX_W-1:0]  cur,
    output logic              any_en,
    output logic [IDX_W-1:0]  first_idx,
    output logic              has_next,
    output logic [IDX_W-1:0]  next_idx
);
    logic [N_SENS-1:0] above;

    for (genvar g = 0; g < N_SENS; g++) begin : g_above
        assign above[g] = en[g] && (32'(g) > 32'(cur));
    end

    always_comb begin
        any_en    = |en;
        has_next  = |above;
        first_idx = '0;
        next_idx  = '0;
        for (int i = N_SENS - 1; i >= 0; i--) begin
            if (en[i])    first_idx = IDX_W'(i);
            if (above[i]) next_idx  = IDX_W'(i);
        end
    end
endmodule

// File: rtl/scan_sched.sv
module scan_sched
    import scan_sched_pkg::*;
#(
    parameter int N_SENS     = 4,
    parameter int IVAL_W     = 10,
    parameter int UNIT_SHIFT = 8,
    localparam int IDX_W     = $clog2(N_SENS),
    localparam int CNT_W     = 2 * IVAL_W + UNIT_SHIFT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clk_en,
    input  logic [N_SENS-1:0]         sensor_en,
    input  logic [N_SENS-1:0]         imm_en,
    input  logic [N_SENS*FCODE_W-1:0] filt_code,
    input  logic [IVAL_W-1:0]         period_unit,
    input  logic [IVAL_W-1:0]         filt_ival,
    input  logic [IVAL_W-1:0]         sens_ival,
    input  logic [IVAL_W-1:0]         grp_ival,
    output logic                      req_valid,
    output logic [IDX_W-1:0]          req_sensor
);
    typedef struct packed {
        scan_st_e         st;
        logic [IDX_W-1:0] cur;
        logic [SMP_W-1:0] smp;
        logic [CNT_W-1:0] cnt;
    } sched_s;

    localparam sched_s SCHED_RST = '{st: ST_IDLE, cur: '0, smp: '0, cnt: '0};

    sched_s s_d, s_q;

    logic              any_en, has_next;
    logic [IDX_W-1:0]  first_idx, next_idx;
    logic [SMP_W-1:0]  need;
    logic [IVAL_W-1:0] sel_units;
    logic [CNT_W-1:0]  dly_cycles, wait_len;
    logic              force_one;
    logic [IDX_W-1:0]  nxt_cur;
    logic [SMP_W-1:0]  nxt_smp;

    scan_pick #(.N_SENS(N_SENS)) u_pick (
        .en        (sensor_en),
        .cur       (s_q.cur),
        .any_en    (any_en),
        .first_idx (first_idx),
        .has_next  (has_next),
        .next_idx  (next_idx)
    );

    scan_delay #(.IVAL_W(IVAL_W), .UNIT_SHIFT(UNIT_SHIFT)) u_delay (
        .units  (sel_units),
        .period (period_unit),
        .cycles (dly_cycles)
    );

    // Decide the target of the next request and the wait before it.
    always_comb begin
        need      = imm_en[s_q.cur] ? SMP_W'(1) : burst_len(filt_code[s_q.cur*FCODE_W +: FCODE_W]);
        force_one = 1'b0;
        if ((s_q.smp + SMP_W'(1)) < need) begin
            sel_units = filt_ival;
            nxt_cur   = s_q.cur;
            nxt_smp   = s_q.smp + SMP_W'(1);
        end else if (has_next) begin
            sel_units = sens_ival;
            force_one = imm_en[s_q.cur];
            nxt_cur   = next_idx;
            nxt_smp   = '0;
        end else begin
            sel_units = grp_ival;
            nxt_cur   = first_idx;
            nxt_smp   = '0;
        end
        wait_len = force_one ? CNT_W'(1) : dly_cycles;
    end

    always_comb begin
        s_d = s_q;
        if (!clk_en) begin
            s_d = SCHED_RST;
        end else begin
            case (s_q.st)
                ST_IDLE: begin
                    if (any_en) begin
                        s_d.st  = ST_REQ;
                        s_d.cur = first_idx;
                        s_d.smp = '0;
                    end
                end
                ST_REQ: begin
                    if (!any_en) begin
                        s_d = SCHED_RST;
                    end else begin
                        s_d.cur = nxt_cur;
                        s_d.smp = nxt_smp;
                        if (wait_len == CNT_W'(1)) begin
                            s_d.st = ST_REQ;
                        end else begin
                            s_d.st  = ST_WAIT;
                            s_d.cnt = wait_len - CNT_W'(1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (!any_en)                   s_d = SCHED_RST;
                    else if (s_q.cnt == CNT_W'(1)) s_d.st = ST_REQ;
                    else                           s_d.cnt = s_q.cnt - CNT_W'(1);
                end
                default: s_d = SCHED_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SCHED_RST;
        else        s_q <= s_d;
    end

    assign req_valid  = clk_en && (s_q.st == ST_REQ);
    assign req_sensor = s_q.cur;

    // R1: a low enable leaves the sequencer idle on the next cycle
    p_gate_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> (s_q.st == ST_IDLE));

    // R2: leaving idle, the request goes to the lowest enabled sensor
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && clk_en && any_en)
        |=> (!clk_en || (req_valid && req_sensor == $past(first_idx))));

    // R3: a running wait counts down by exactly one per cycle
    p_wait_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WAIT && clk_en && any_en && s_q.cnt > CNT_W'(1))
        |=> (s_q.st == ST_WAIT && s_q.cnt == $past(s_q.cnt) - CNT_W'(1)));

    // R4: a request never exceeds the burst length of its sensor
    p_smp_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_REQ && clk_en) |-> (s_q.smp < need));

    // R9: an empty map produces no request on the next cycle
    p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sensor_en == '0) |=> !req_valid);

endmodule

// File: tb/tb_scan_sched.sv
`timescale 1ns/1ps
module tb_scan_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic [3:0]  sensor_en = '0;
    logic [3:0]  imm_en = '0;
    logic [11:0] filt_code = '0;
    logic [9:0]  period_unit = 10'd1;
    logic [9:0]  filt_ival = '0;
    logic [9:0]  sens_ival = '0;
    logic [9:0]  grp_ival = '0;
    logic        req_valid;
    logic [1:0]  req_sensor;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scan_sched dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sensor_en(sensor_en),
        .imm_en(imm_en), .filt_code(filt_code), .period_unit(period_unit),
        .filt_ival(filt_ival), .sens_ival(sens_ival), .grp_ival(grp_ival),
        .req_valid(req_valid), .req_sensor(req_sensor)
    );

    typedef struct packed {
        logic [3:0]  emap;
        logic [3:0]  imm;
        logic [11:0] fc;
        logic [9:0]  per;
        logic [9:0]  fi;
        logic [9:0]  si;
        logic [9:0]  gi;
        logic [3:0]  n;
        logic [15:0] sq;
        logic [79:0] gp;
    } vec_t;

    localparam int NVEC = 9;
    // sq holds expected sensor k in bits 2k+1:2k; gp holds expected gap k in bits 10k+9:10k
    localparam vec_t VEC [NVEC] = '{
        '{emap:4'b0001, imm:4'b0000, fc:12'h000, per:10'd1, fi:10'd0, si:10'd0, gi:10'd1, n:4'd4,
          sq:16'h0000, gp:{40'd0, 10'd256, 10'd256, 10'd256, 10'd0}},
        '{emap:4'b0101, imm:4'b0000, fc:12'h000, per:10'd1, fi:10'd0, si:10'd1, gi:10'd0, n:4'd4,
          sq:16'h0088, gp:{40'd0, 10'd256, 10'd1, 10'd256, 10'd0}},
        '{emap:4'b0010, imm:4'b0000, fc:12'h008, per:10'd1, fi:10'd1, si:10'd0, gi:10'd2, n:4'd4,
          sq:16'h0055, gp:{40'd0, 10'd256, 10'd512, 10'd256, 10'd0}},
        '{emap:4'b1001, imm:4'b0000, fc:12'h002, per:10'd1, fi:10'd0, si:10'd2, gi:10'd0, n:4'd8,
          sq:16'h0300, gp:{10'd1, 10'd1, 10'd1, 10'd512, 10'd1, 10'd1, 10'd1, 10'd0}},
        '{emap:4'b0011, imm:4'b0001, fc:12'h001, per:10'd1, fi:10'd1, si:10'd1, gi:10'd1, n:4'd4,
          sq:16'h0044, gp:{40'd0, 10'd1, 10'd256, 10'd1, 10'd0}},
        '{emap:4'b1100, imm:4'b0000, fc:12'h000, per:10'd2, fi:10'd0, si:10'd1, gi:10'd1, n:4'd4,
          sq:16'h00EE, gp:{40'd0, 10'd512, 10'd512, 10'd512, 10'd0}},
        '{emap:4'b0001, imm:4'b0000, fc:12'h006, per:10'd1, fi:10'd1, si:10'd0, gi:10'd0, n:4'd3,
          sq:16'h0000, gp:{50'd0, 10'd1, 10'd1, 10'd0}},
        '{emap:4'b0011, imm:4'b0000, fc:12'h003, per:10'd1, fi:10'd0, si:10'd0, gi:10'd0, n:4'd8,
          sq:16'h1000, gp:{10'd1, 10'd1, 10'd1, 10'd1, 10'd1, 10'd1, 10'd1, 10'd0}},
        '{emap:4'b0011, imm:4'b0000, fc:12'h000, per:10'd0, fi:10'd0, si:10'd5, gi:10'd5, n:4'd4,
          sq:16'h0044, gp:{40'd0, 10'd1, 10'd1, 10'd1, 10'd0}}
    };

    function automatic string vec_tag(input int k);
        case (k)
            0: return "R7 R3";
            1: return "R6 R7 R3";
            2: return "R5 R7 R4";
            3: return "R4 R5 R6";
            4: return "R8";
            5: return "R3 R6 R7";
            6: return "R4";
            7: return "R4 R6";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_cfg(input vec_t v);
        @(negedge clk);
        clk_en = 1'b0;
        sensor_en = v.emap; imm_en = v.imm; filt_code = v.fc;
        period_unit = v.per; filt_ival = v.fi; sens_ival = v.si; grp_ival = v.gi;
        @(negedge clk);
    endtask

    task automatic run_vec(input int k);
        vec_t v = VEC[k];
        int cyc = 0;
        int got = 0;
        int last = 0;
        apply_cfg(v);
        clk_en = 1'b1;
        while (got < int'(v.n) && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (req_valid) begin
                if (got == 0)
                    chk(cyc == 1, "R2", $sformatf("vec %0d first request cycle", k), cyc, 1);
                chk(req_sensor == v.sq[2*got +: 2], vec_tag(k),
                    $sformatf("vec %0d request %0d sensor", k, got), int'(req_sensor), int'(v.sq[2*got +: 2]));
                if (got > 0)
                    chk(cyc - last == int'(v.gp[10*got +: 10]), vec_tag(k),
                        $sformatf("vec %0d request %0d gap", k, got), cyc - last, int'(v.gp[10*got +: 10]));
                last = cyc;
                got++;
            end
        end
        chk(got == int'(v.n), vec_tag(k), $sformatf("vec %0d request count", k), got, int'(v.n));
        clk_en = 1'b0;
    endtask

    task automatic quiet_for(input int ncyc, input string req, input string what);
        int seen = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (req_valid) seen++;
        end
        chk(seen == 0, req, what, seen, 0);
    endtask

    // R4: count the burst to sensor 0 before the first request to sensor 1
    task automatic burst_count(input logic [2:0] code, input int exp);
        vec_t v = VEC[7];
        int cnt = 0;
        bit hit = 1'b0;
        v.fc = {9'd0, code};
        apply_cfg(v);
        clk_en = 1'b1;
        for (int i = 0; i < 200 && !hit; i++) begin
            @(negedge clk);
            if (req_valid) begin
                if (req_sensor == 2'd1) hit = 1'b1;
                else cnt++;
            end
        end
        chk(hit && cnt == exp, "R4", $sformatf("burst length for code %0d", code), cnt, exp);
        clk_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state and idle while disabled
        @(negedge clk);
        chk(req_valid == 1'b0, "R1", "request during reset", int'(req_valid), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sensor_en = 4'b1111;
        quiet_for(600, "R1", "requests with clock enable low");

        for (int k = 0; k < NVEC; k++) run_vec(k);

        // R9: empty map with enable high
        apply_cfg(VEC[0]);
        sensor_en = 4'b0000;
        clk_en = 1'b1;
        quiet_for(2000, "R9", "requests with empty sensor map");
        clk_en = 1'b0;

        // R1: dropping the enable mid-wait restarts the scan at the lowest sensor
        apply_cfg(VEC[1]);
        clk_en = 1'b1;
        repeat (10) @(negedge clk);
        clk_en = 1'b0;
        @(negedge clk);
        chk(req_valid == 1'b0, "R1", "request right after disable", int'(req_valid), 0);
        clk_en = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b1, "R1", "restart request present", int'(req_valid), 1);
        chk(req_sensor == 2'd0, "R1", "restart sensor", int'(req_sensor), 0);
        clk_en = 1'b0;

        burst_count(3'd4, 10);
        burst_count(3'd5, 18);
        burst_count(3'd7, 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule